// File: doc/BRIEF.md
# Masked packed half-precision adder

This block is a registered SIMD datapath that adds two vectors of IEEE binary16 values lane by lane. The vector length is 128, 256 or 512 bits, giving 8, 16 or 32 active lanes. Each lane produces a correctly rounded sum under one of four rounding modes. A lane mask can turn lanes off; a turned-off lane is either cleared or left holding the value it had in the old destination vector. The second operand can be a single element (its element 0) applied to every lane, and an alternate rounding field applies in exactly one operand mode.

Each operation is presented with `in_valid` for one cycle. One cycle later `out_valid` pulses, and the 512-bit result and five exception flags appear together. Between operations, the result and flags keep their last values. Result bits above the selected vector length are always zero. The flags are the OR of the flags of every lane that actually computed a sum.

Top module: `hp_vec_add`

## Requirements
- R1: `vlen_sel` 00 selects 8 active lanes, 01 selects 16, and 10 or 11 selects 32. Lane i occupies bits [16i+15:16i] of every vector.
- R2: An active lane whose mask bit is set, or any active lane when `mask_en` is 0, outputs the binary16 sum (bit 15 sign, bits 14:10 exponent, bits 9:0 fraction) of its `src_a` and `src_b` elements, rounded per the selected mode: 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero.
- R3: With `mask_en`=1 and `zero_mode`=1, an active lane whose mask bit is clear outputs 0x0000.
- R4: With `mask_en`=1 and `zero_mode`=0, an active lane whose mask bit is clear outputs its `dest_old` element unchanged.
- R5: When `b_from_mem`=1 and `bcast`=1, every lane adds `src_b[15:0]` instead of its own `src_b` element.
- R6: `rc_embed` is the rounding mode only when 32 lanes are selected, `b_from_mem`=0 and `bcast`=1; otherwise `rc_global` is used.
- R7: All result bits at and above the selected vector length are 0.
- R8: A signaling NaN operand (exponent 31, fraction nonzero, fraction bit 9 clear), or infinities of opposite sign, sets invalid and gives 0x7E00. Otherwise a quiet NaN in `src_a` is passed through, then a quiet NaN in `src_b`; a single infinity is passed through.
- R9: An exact zero sum is +0 when the operands' signs differ, except under mode 01, where it is -0; same-sign zeros keep their sign.
- R10: A rounded magnitude of 65536 or more sets overflow and inexact and gives infinity under nearest-even, the largest finite value 0x7BFF (with sign) under toward-zero, and whichever of the two lies in the rounding direction for the directed modes. Any other rounding that discards nonzero bits sets inexact.
- R11: `exc_flags` bits are [4] invalid, [3] denormal operand (either operand is a nonzero subnormal), [2] overflow, [1] underflow (tiny and inexact; never set, since a sum that lands below the normal range is exact), [0] inexact.
- R12: `exc_flags` is the OR over lanes that computed a sum only; masked-off lanes and lanes above the vector length contribute nothing.
- R13: `out_valid` is `in_valid` delayed by one cycle; result and flags update only on an accepted operation and hold otherwise; reset clears outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| src_a | input | 512 | First operand vector |
| src_b | input | 512 | Second operand vector |
| dest_old | input | 512 | Previous destination, used by merge masking |
| lane_mask | input | 32 | Per-lane enable bits |
| mask_en | input | 1 | 1 = apply `lane_mask` |
| zero_mode | input | 1 | 1 = clear masked lanes, 0 = merge |
| vlen_sel | input | 2 | Vector length select |
| bcast | input | 1 | Broadcast / rounding-override flag |
| b_from_mem | input | 1 | Second operand comes from memory |
| rc_embed | input | 2 | Rounding mode carried with the operation |
| rc_global | input | 2 | Default rounding mode |
| out_valid | output | 1 | Result valid strobe |
| result | output | 512 | Result vector |
| exc_flags | output | 5 | Exception flags of the last operation |

## Verification
The bench aims at the rounding edges: ties between two representable values, tiny addends that only directed modes notice, and overflow under each mode. A design that got these wrong would be off by one unit in the last place or return infinity where 0x7BFF is due. It sets up the cases where the embedded rounding field must and must not take effect, and where broadcast must not happen because the operand is a register. A wrong decode there gives results rounded the wrong way or sums against the wrong element. It also plants signaling NaNs in masked lanes and in lanes beyond the vector length, where a design that ORs flags from every lane would raise invalid. It checks the signed-zero rule under the minus-infinity mode and merge versus zero masking. Pseudo-random vectors under every mode and length cover the rest of the arithmetic.

// File: rtl/hp_add_pkg.sv
package hp_add_pkg;
    localparam int HW        = 16;
    localparam int FRAC_W    = 10;
    localparam int EXP_W     = 5;
    localparam int MAX_LANES = 32;
    localparam int MAG_W     = FRAC_W + 1 + (2**EXP_W - 3) + 1;
    localparam int ENC_W     = HW + 1;

    typedef enum logic [1:0] {
        RND_NEAR = 2'b00,
        RND_DOWN = 2'b01,
        RND_UP   = 2'b10,
        RND_ZERO = 2'b11
    } rnd_t;

    typedef struct packed {
        logic invalid;
        logic denorm;
        logic overflow;
        logic underflow;
        logic inexact;
    } exc_t;
endpackage

// File: rtl/hp_add_lane.sv
module hp_add_lane
    import hp_add_pkg::*;
(
    input  logic [HW-1:0] op_a,
    input  logic [HW-1:0] op_b,
    input  rnd_t          rnd,
    output logic [HW-1:0] sum,
    output exc_t          flags
);
    logic              a_nan, b_nan, a_snan, b_snan, a_inf, b_inf, a_sub, b_sub;
    logic [MAG_W-1:0]  mag_a, mag_b, mag_s, low_mask;
    logic              sgn, rbit, stk, lost, up, ovf, tiny, to_inf;
    logic [5:0]        shamt;
    logic [FRAC_W-1:0] kept;
    logic [ENC_W-1:0]  enc, enc_r;
    int                lead;

    always_comb begin
        a_nan  = (&op_a[14:10]) && (|op_a[9:0]);
        b_nan  = (&op_b[14:10]) && (|op_b[9:0]);
        a_snan = a_nan && !op_a[9];
        b_snan = b_nan && !op_b[9];
        a_inf  = (&op_a[14:10]) && !(|op_a[9:0]);
        b_inf  = (&op_b[14:10]) && !(|op_b[9:0]);
        a_sub  = !(|op_a[14:10]) && (|op_a[9:0]);
        b_sub  = !(|op_b[14:10]) && (|op_b[9:0]);

        // exact fixed-point magnitudes in units of the smallest subnormal
        mag_a = MAG_W'({|op_a[14:10], op_a[9:0]})
                << ((op_a[14:10] == 5'd0) ? 5'd0 : op_a[14:10] - 5'd1);
        mag_b = MAG_W'({|op_b[14:10], op_b[9:0]})
                << ((op_b[14:10] == 5'd0) ? 5'd0 : op_b[14:10] - 5'd1);

        if (op_a[15] == op_b[15]) begin
            mag_s = mag_a + mag_b;
            sgn   = op_a[15];
        end else if (mag_a >= mag_b) begin
            mag_s = mag_a - mag_b;
            sgn   = op_a[15];
        end else begin
            mag_s = mag_b - mag_a;
            sgn   = op_b[15];
        end

        lead = 0;
        for (int i = 0; i < MAG_W; i++) begin
            if (mag_s[i]) lead = i;
        end
        shamt    = (lead > FRAC_W) ? 6'(lead - FRAC_W) : 6'd0;
        kept     = FRAC_W'(mag_s >> shamt);
        rbit     = (shamt != 6'd0) && mag_s[shamt - 6'd1];
        low_mask = ((MAG_W'(1) << shamt) - MAG_W'(1)) >> 1;
        stk      = |(mag_s & low_mask);
        lost     = rbit || stk;

        if (shamt == 6'd0) enc = ENC_W'(mag_s[HW-2:0]);
        else               enc = ((ENC_W'(shamt) + ENC_W'(1)) << FRAC_W) | ENC_W'(kept);

        case (rnd)
            RND_NEAR: up = rbit && (stk || kept[0]);
            RND_DOWN: up = lost && sgn;
            RND_UP:   up = lost && !sgn;
            default:  up = 1'b0;
        endcase
        enc_r  = enc + ENC_W'(up);
        ovf    = enc_r >= ENC_W'(16'h7C00);
        tiny   = enc_r < ENC_W'(16'h0400);
        to_inf = (rnd == RND_NEAR) || (rnd == RND_DOWN && sgn) || (rnd == RND_UP && !sgn);

        flags        = '0;
        flags.denorm = a_sub || b_sub;
        if (a_snan || b_snan || (a_inf && b_inf && (op_a[15] != op_b[15]))) begin
            sum           = 16'h7E00;
            flags.invalid = 1'b1;
        end else if (a_nan) begin
            sum = op_a;
        end else if (b_nan) begin
            sum = op_b;
        end else if (a_inf) begin
            sum = op_a;
        end else if (b_inf) begin
            sum = op_b;
        end else if (mag_s == '0) begin
            sum = {(op_a[15] == op_b[15]) ? op_a[15] : (rnd == RND_DOWN), 15'd0};
        end else if (ovf) begin
            sum            = {sgn, to_inf ? 15'h7C00 : 15'h7BFF};
            flags.overflow = 1'b1;
            flags.inexact  = 1'b1;
        end else begin
            sum             = {sgn, enc_r[HW-2:0]};
            flags.inexact   = lost;
            flags.underflow = tiny && lost;
        end
    end
endmodule

// File: rtl/hp_mode_sel.sv
module hp_mode_sel
    import hp_add_pkg::*;
#(
    parameter int LANES = MAX_LANES
) (
    input  logic [1:0]       vlen_sel,
    input  logic             mask_en,
    input  logic [LANES-1:0] lane_mask,
    input  logic             bcast,
    input  logic             b_from_mem,
    input  logic [1:0]       rc_embed,
    input  logic [1:0]       rc_global,
    output logic [LANES-1:0] lane_live,
    output logic [LANES-1:0] lane_take,
    output logic             use_bcast,
    output rnd_t             rnd
);
    localparam int CW = $clog2(LANES) + 1;
    logic [CW-1:0] lanes_on;

    always_comb begin
        case (vlen_sel)
            2'b00:   lanes_on = CW'(LANES / 4);
            2'b01:   lanes_on = CW'(LANES / 2);
            default: lanes_on = CW'(LANES);
        endcase
        use_bcast = b_from_mem && bcast;
        rnd = (vlen_sel[1] && !b_from_mem && bcast) ? rnd_t'(rc_embed) : rnd_t'(rc_global);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_live[i] = CW'(i) < lanes_on;
        assign lane_take[i] = lane_live[i] && (!mask_en || lane_mask[i]);
    end
endmodule

// File: rtl/hp_vec_add.sv
module hp_vec_add
    import hp_add_pkg::*;
#(
    parameter int LANES = MAX_LANES,
    localparam int VW   = LANES * HW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VW-1:0]    src_a,
    input  logic [VW-1:0]    src_b,
    input  logic [VW-1:0]    dest_old,
    input  logic [LANES-1:0] lane_mask,
    input  logic             mask_en,
    input  logic             zero_mode,
    input  logic [1:0]       vlen_sel,
    input  logic             bcast,
    input  logic             b_from_mem,
    input  logic [1:0]       rc_embed,
    input  logic [1:0]       rc_global,
    output logic             out_valid,
    output logic [VW-1:0]    result,
    output logic [4:0]       exc_flags
);
    typedef struct packed {
        logic          valid;
        logic [VW-1:0] res;
        exc_t          flags;
    } state_t;

    state_t           st_d, st_q;
    logic [LANES-1:0] lane_live, lane_take;
    logic             use_bcast;
    rnd_t             rnd;
    logic [HW-1:0]    lane_sum [LANES];
    exc_t             lane_flg [LANES];

    hp_mode_sel #(.LANES(LANES)) u_mode (
        .vlen_sel   (vlen_sel),
        .mask_en    (mask_en),
        .lane_mask  (lane_mask),
        .bcast      (bcast),
        .b_from_mem (b_from_mem),
        .rc_embed   (rc_embed),
        .rc_global  (rc_global),
        .lane_live  (lane_live),
        .lane_take  (lane_take),
        .use_bcast  (use_bcast),
        .rnd        (rnd)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [HW-1:0] b_elem;
        assign b_elem = use_bcast ? src_b[HW-1:0] : src_b[i*HW +: HW];
        hp_add_lane u_add (
            .op_a  (src_a[i*HW +: HW]),
            .op_b  (b_elem),
            .rnd   (rnd),
            .sum   (lane_sum[i]),
            .flags (lane_flg[i])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.flags = '0;
            for (int i = 0; i < LANES; i++) begin
                if (!lane_live[i])    st_d.res[i*HW +: HW] = '0;
                else if (lane_take[i]) st_d.res[i*HW +: HW] = lane_sum[i];
                else if (zero_mode)    st_d.res[i*HW +: HW] = '0;
                else                   st_d.res[i*HW +: HW] = dest_old[i*HW +: HW];
                if (lane_take[i]) st_d.flags = exc_t'(st_d.flags | lane_flg[i]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign result    = st_q.res;
    assign exc_flags = st_q.flags;
endmodule

// File: rtl/hp_add_chk.sv
module hp_add_chk
    import hp_add_pkg::*;
#(
    parameter int LANES = MAX_LANES,
    localparam int VW   = LANES * HW
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [VW-1:0]    src_a,
    input logic [VW-1:0]    dest_old,
    input logic [LANES-1:0] lane_mask,
    input logic             mask_en,
    input logic             zero_mode,
    input logic [1:0]       vlen_sel,
    input logic             out_valid,
    input logic [VW-1:0]    result,
    input logic [4:0]       exc_flags
);
    assert_valid_rise_R13: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_drop_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result) && $stable(exc_flags));
    assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && vlen_sel == 2'b00 |=> result[VW-1:VW/4] == '0);
    assert_half_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && vlen_sel == 2'b01 |=> result[VW-1:VW/2] == '0);
    assert_zeroing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && mask_en && zero_mode && !lane_mask[0] |=> result[HW-1:0] == '0);
    assert_merge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && mask_en && !zero_mode && !lane_mask[0]
        |=> result[HW-1:0] == $past(dest_old[HW-1:0]));
    assert_no_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && mask_en && lane_mask == '0 |=> exc_flags == 5'd0);
    assert_snan_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !mask_en && src_a[HW-1:0] == 16'h7C01
        |=> exc_flags[4] && result[HW-1:0] == 16'h7E00);
endmodule

bind hp_vec_add hp_add_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/test_hp_vec_add.sv
`timescale 1ns/100ps
module test_hp_vec_add;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [511:0] src_a = '0, src_b = '0, dest_old = '0;
    logic [31:0]  lane_mask = '0;
    logic         mask_en = 1'b0, zero_mode = 1'b0, bcast = 1'b0, b_from_mem = 1'b0;
    logic [1:0]   vlen_sel = 2'b10, rc_embed = 2'b00, rc_global = 2'b00;
    logic         out_valid;
    logic [511:0] result;
    logic [4:0]   exc_flags;

    int           nchk = 0, nerr = 0;
    string        cur_tag = "R13", exp_tag = "R13";
    logic         exp_v = 1'b0;
    logic [511:0] exp_r = '0;
    logic [4:0]   exp_f = '0;
    logic [31:0]  seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    hp_vec_add i_hp_vec_add (.*);

    function automatic logic [20:0] ref_add(input logic [15:0] a, input logic [15:0] b,
                                            input logic [1:0] rm);
        int ea, eb, e;
        logic an, bn, asg, bsg, ai, bi, neg, rb, st, inx, up, big;
        logic [4:0] f;
        longint va, vb, s, m, enc;
        ea  = int'(a[14:10]);
        eb  = int'(b[14:10]);
        an  = (ea == 31) && (a[9:0] != 0);
        bn  = (eb == 31) && (b[9:0] != 0);
        asg = an && !a[9];
        bsg = bn && !b[9];
        ai  = (ea == 31) && (a[9:0] == 0);
        bi  = (eb == 31) && (b[9:0] == 0);
        f   = 5'd0;
        f[3] = ((ea == 0) && (a[9:0] != 0)) || ((eb == 0) && (b[9:0] != 0));
        if (asg || bsg || (ai && bi && a[15] != b[15])) begin
            f[4] = 1'b1;
            return {f, 16'h7E00};
        end
        if (an) return {f, a};
        if (bn) return {f, b};
        if (ai) return {f, a};
        if (bi) return {f, b};
        va = (ea == 0) ? longint'(a[9:0]) : (longint'(a[9:0]) + 1024) << (ea - 1);
        vb = (eb == 0) ? longint'(b[9:0]) : (longint'(b[9:0]) + 1024) << (eb - 1);
        if (a[15]) va = -va;
        if (b[15]) vb = -vb;
        s   = va + vb;
        neg = s < 0;
        m   = neg ? -s : s;
        if (m == 0) return {f, (a[15] == b[15]) ? a[15] : (rm == 2'b01), 15'd0};
        e = 1; rb = 1'b0; st = 1'b0;
        while (m >= 2048) begin
            st = st | rb;
            rb = (m % 2) == 1;
            m  = m / 2;
            e  = e + 1;
        end
        enc = (e == 1) ? m : longint'(e) * 1024 + m - 1024;
        inx = rb | st;
        case (rm)
            2'b00:   up = rb && (st || (m % 2) == 1);
            2'b01:   up = inx && neg;
            2'b10:   up = inx && !neg;
            default: up = 1'b0;
        endcase
        if (up) enc = enc + 1;
        if (enc >= 31 * 1024) begin
            f[2] = 1'b1;
            f[0] = 1'b1;
            big = (rm == 2'b00) || (rm == 2'b01 && neg) || (rm == 2'b10 && !neg);
            return {f, neg, big ? 15'h7C00 : 15'h7BFF};
        end
        f[0] = inx;
        return {f, neg, 15'(enc)};
    endfunction

    function automatic logic [516:0] ref_vec();
        int         nl;
        logic [1:0] rm;
        logic [15:0] bj;
        logic [20:0] r;
        logic [511:0] res;
        logic [4:0] f;
        nl  = (vlen_sel == 2'b00) ? 8 : (vlen_sel == 2'b01) ? 16 : 32;
        rm  = (vlen_sel[1] && !b_from_mem && bcast) ? rc_embed : rc_global;
        res = '0;
        f   = 5'd0;
        for (int j = 0; j < nl; j++) begin
            if (!mask_en || lane_mask[j]) begin
                bj = (b_from_mem && bcast) ? src_b[15:0] : src_b[j*16 +: 16];
                r  = ref_add(src_a[j*16 +: 16], bj, rm);
                res[j*16 +: 16] = r[15:0];
                f = f | r[20:16];
            end else if (!zero_mode) begin
                res[j*16 +: 16] = dest_old[j*16 +: 16];
            end
        end
        return {f, res};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_v <= 1'b0;
            exp_r <= '0;
            exp_f <= '0;
        end else begin
            exp_v <= in_valid;
            if (in_valid) begin
                {exp_f, exp_r} <= ref_vec();
                exp_tag <= cur_tag;
            end
        end
    end

    task automatic check_out(input string tag);
        nchk++;
        if (out_valid !== exp_v) begin
            nerr++;
            $display("FAIL %s out_valid: got %b expected %b", tag, out_valid, exp_v);
        end
        nchk++;
        if (result !== exp_r) begin
            nerr++;
            $display("FAIL %s result: got %h expected %h", tag, result, exp_r);
        end
        nchk++;
        if (exc_flags !== exp_f) begin
            nerr++;
            $display("FAIL %s flags: got %b expected %b", tag, exc_flags, exp_f);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) check_out(exp_tag);
    end

    function automatic logic [511:0] rvec();
        logic [511:0] v;
        for (int k = 0; k < 16; k++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            v[k*32 +: 32] = {seed[31:16], seed[15:0] ^ 16'h5a3c};
            seed = seed * 32'd1103515245 + 32'd12345;
            v[k*32 +: 32] = v[k*32 +: 32] ^ seed;
        end
        return v;
    endfunction

    task automatic op(input string tag, input logic [511:0] a, input logic [511:0] b,
                      input logic [511:0] d, input logic [31:0] m, input logic men,
                      input logic zm, input logic [1:0] vl, input logic bc,
                      input logic mem, input logic [1:0] re, input logic [1:0] rg);
        @(negedge clk);
        cur_tag = tag; src_a = a; src_b = b; dest_old = d; lane_mask = m;
        mask_en = men; zero_mode = zm; vlen_sel = vl; bcast = bc;
        b_from_mem = mem; rc_embed = re; rc_global = rg; in_valid = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            src_a = rvec();
            src_b = rvec();
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        nchk++;
        nerr++;
        $display("FAIL R13 watchdog expired: got running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check_out("R13 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R2: basic sums and random vectors under every rounding mode
        op("R2", {32{16'h3C00}}, {32{16'h3C00}}, '0, '0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 2'b00, 2'b00);
        for (int t = 0; t < 40; t++)
            op("R2", rvec(), rvec(), rvec(), '0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 2'b00, 2'(t));
        // R1 / R7: shorter vector lengths
        for (int t = 0; t < 6; t++)
            op("R1", rvec(), rvec(), rvec(), '1, 1'b0, 1'b0, 2'(t % 2), 1'b0, 1'b0, 2'b00, 2'(t));
        op("R7", rvec(), rvec(), rvec(), '1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 2'b00, 2'b00);
        op("R1", rvec(), rvec(), rvec(), '0, 1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 2'b00, 2'b00);
        // R3 / R4: zeroing and merging masks
        op("R3", rvec(), rvec(), rvec(), 32'hA5A5_0F0E, 1'b1, 1'b1, 2'b10, 1'b0, 1'b0, 2'b00, 2'b00);
        op("R4", rvec(), rvec(), rvec(), 32'h5A5A_F0F0, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 2'b00, 2'b00);
        op("R4", rvec(), rvec(), rvec(), 32'h0000_0000, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 2'b00, 2'b00);
        // R5: broadcast from memory versus register operand
        op("R5", rvec(), rvec(), rvec(), '0, 1'b0, 1'b0, 2'b10, 1'b1, 1'b1, 2'b00, 2'b01);
        op("R5", rvec(), rvec(), rvec(), '0, 1'b0, 1'b0, 2'b01, 1'b1, 1'b1, 2'b00, 2'b10);
        // R6: embedded rounding only with full length, register operand, flag set
        op("R6", {32{16'h3C00}}, {32{16'h0001}}, '0, '0, 1'b0, 1'b0, 2'b10, 1'b1, 1'b0, 2'b10, 2'b11);
        op("R6", {32{16'h3C00}}, {32{16'h0001}}, '0, '0, 1'b0, 1'b0, 2'b01, 1'b1, 1'b0, 2'b10, 2'b11);
        op("R6", {32{16'h3C00}}, {32{16'h0001}}, '0, '0, 1'b0, 1'b0, 2'b10, 1'b1, 1'b1, 2'b10, 2'b11);
        op("R6", {32{16'h3C00}}, {32{16'h0001}}, '0, '0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 2'b10, 2'b11);
        // R2: ties to even (1 + 2^-11, 1 + 3*2^-11)
        op("R2", {16{16'h3C01, 16'h3C00}}, {32{16'h1000}}, '0, '0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 2'b00, 2'b00);
        // R8: NaN and infinity handling
        op("R8", {32{16'h7C01}}, {32{16'h3C00}}, '0, '0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 2'b00, 2'b00);
        op("R8", {16{16'h7E05, 16'h3C00}}, {16{16'h3C00, 16'hFE11}}, '0, '0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 2'b00, 2'b00);
        op("R8", {16{16'h7C00, 16'h7C00}}, {16{16'hFC00, 16'h4000}}, '0, '0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 2'b00, 2'b00);
        // R9: signed zero results
        for (int t = 0; t < 4; t++)
            op("R9", {16{16'h3C00, 16'h8000}}, {16{16'hBC00, 16'h8000}}, '0, '0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 2'b00, 2'(t));
        // R10: overflow under each mode, both signs
        for (int t = 0; t < 4; t++)
            op("R10", {16{16'h7BFF, 16'hFBFF}}, {16{16'h7BFF, 16'hFBFF}}, '0, '0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 2'b00, 2'(t));
        // R11: subnormal operands, exact subnormal sums
        op("R11", {32{16'h0001}}, {32{16'h83FF}}, '0, '0, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 2'b00, 2'b00);
        // R12: faulty lanes masked off or beyond the length raise nothing
        op("R12", {{31{16'h3C00}}, 16'h7C01}, {32{16'h3C00}}, rvec(), 32'hFFFF_FFFE, 1'b1, 1'b0, 2'b10, 1'b0, 1'b0, 2'b00, 2'b00);
        op("R12", {{16{16'h7C01}}, {16{16'h3C00}}}, {32{16'h3C00}}, rvec(), '1, 1'b1, 1'b1, 2'b01, 1'b0, 1'b0, 2'b00, 2'b00);
        op("R12", rvec(), rvec(), rvec(), '0, 1'b1, 1'b1, 2'b10, 1'b0, 1'b0, 2'b00, 2'b00);
        // R13: outputs hold across idle cycles, then resume
        idle(4);
        op("R13", rvec(), rvec(), rvec(), 32'h1234_5678, 1'b1, 1'b0, 2'b10, 1'b1, 1'b1, 2'b01, 2'b00);
        idle(3);
        finish_run();
    end
endmodule